// File: doc/BRIEF.md
# Sticky Edge-Captured Interrupt Latch

This block collects short event pulses from several sources whose timing is unrelated to the system clock. It turns each pulse into an interrupt request that cannot be lost. Each external source is resynchronised and then passed through a rising-edge detector. A pulse therefore raises one request no matter how many clock cycles it stays high. Each request sets its own sticky pending bit. That bit holds until software reads the status port, and a single level interrupt line reports whether any bit is pending.

A built-in period timer supplies one more source. A prescaler divides the system clock down to a 250 kHz tick. The timer counts 4100 ticks per period, about 16.4 ms. Its terminal-count level stays high for one tick, which is 4 us. A read returns every pending bit and clears only the bits it returned. An edge that lands in the same cycle as the read stays pending for the next read, so events that coincide with each other or with an acknowledge are never merged or dropped.

Top module: `evt_irq_capture`

## Requirements
- R1: An external source that rises is seen after a two-flop synchroniser and an edge detector. Its pending bit (bit i for srcIn[i]) is set at the second rising clock edge after the first edge that samples the input high.
- R2: A pending bit stays set, and irq stays high, for as long as no read is made, however long that is.
- R3: A pulse that stays high for many cycles produces exactly one pending event.
- R4: Sources that rise in the same cycle are each captured in their own bit. No source masks another.
- R5: While rdEn is high, rdData returns the pending bits. The clock edge that ends the read clears exactly those bits. A new edge that occurs in the read cycle stays pending and appears in the next read.
- R6: irq is the OR of the pending bits. It falls one cycle after a read that leaves nothing pending.
- R7: The timer source sits at bit NUM_EXT, the top bit. It produces one event every (TIMER_RELOAD+1)*CLK_DIV clock cycles: one event per TIMER_RELOAD+1 prescaler ticks, where a tick comes every CLK_DIV cycles.
- R8: rdData is all zeros while rdEn is low.
- R9: An active-low reset clears all pending bits and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_EXT | Event inputs, asynchronous to clk |
| rdEn | input | 1 | Status read strobe; the read acknowledges what it returns |
| rdData | output | NUM_EXT+1 | Pending bits during a read; bit NUM_EXT is the timer |
| irq | output | 1 | Level interrupt request, high while any bit is pending |

## Verification
The properties assume that rdEn is synchronous to clk. They also assume that each source returns low and is sampled low at least once between pulses; otherwise two pulses merge into one edge. The stimulus changes srcIn and rdEn only on falling clock edges. It holds pulses for one or more cycles and leaves gaps of several cycles. The coincidence checks place a new edge inside the read cycle on purpose.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic tick;     // one-cycle 250 kHz prescaler strobe
    logic timerTc;  // timer terminal-count level (one tick wide)
    logic ackRead;  // status read in progress this cycle
  } ctl_strobe_t;
endpackage

// File: rtl/evt_sync2.sv
module evt_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic stage1Q;
  logic stage2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
    end else begin
      stage1Q <= asyncIn;
      stage2Q <= stage1Q;
    end
  end

  assign syncOut = stage2Q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int CLK_DIV      = 1000,
  parameter int TIMER_RELOAD = 4099
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  output ctl_strobe_t ctl
);
  localparam int PRE_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TMR_W = $clog2(TIMER_RELOAD + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_DIV - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(TIMER_RELOAD);

  logic [PRE_W-1:0] preCntQ;
  logic [TMR_W-1:0] tmrCntQ;
  logic             tickNow;

  // Prescaler: one tick every CLK_DIV cycles.
  generate
    if (CLK_DIV > 1) begin : g_div
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  preCntQ <= '0;
        else if (preCntQ == PRE_LAST) preCntQ <= '0;
        else                        preCntQ <= preCntQ + 1'b1;
      end
      assign tickNow = (preCntQ == PRE_LAST);
    end else begin : g_nodiv
      assign preCntQ = '0;
      assign tickNow = 1'b1;
    end
  endgenerate

  // Down-counting period timer, reloads after the zero tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmrCntQ <= TMR_LOAD;
    else if (tickNow) begin
      if (tmrCntQ == '0)      tmrCntQ <= TMR_LOAD;
      else                    tmrCntQ <= tmrCntQ - 1'b1;
    end
  end

  always_comb begin
    ctl.tick    = tickNow;
    ctl.timerTc = (tmrCntQ == '0);
    ctl.ackRead = rdEn;
  end
endmodule

// File: rtl/evt_irq_dpath.sv
module evt_irq_dpath
  import evt_irq_pkg::*;
#(
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] srcIn,
  input  ctl_strobe_t        ctl,
  output logic [NUM_EXT:0]   pendingVec,
  output logic [NUM_EXT:0]   edgeVec,
  output logic [NUM_EXT:0]   rdData
);
  localparam int NUM_SRC = NUM_EXT + 1;

  logic [NUM_SRC-1:0] levelVec;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] pendingQ;

  // External sources are resynchronised; the timer is already in-domain.
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i < NUM_EXT) begin : g_ext
        evt_sync2 u_sync (
          .clk    (clk),
          .rstN   (rstN),
          .asyncIn(srcIn[i]),
          .syncOut(levelVec[i])
        );
      end else begin : g_tmr
        assign levelVec[i] = ctl.timerTc;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= levelVec;
  end

  assign edgeVec = levelVec & ~prevQ;

  // Read clears what it returns; same-cycle edges survive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= (ctl.ackRead ? '0 : pendingQ) | edgeVec;
  end

  assign pendingVec = pendingQ;
  assign rdData     = ctl.ackRead ? pendingQ : '0;
endmodule

// File: rtl/evt_irq_capture.sv
module evt_irq_capture
  import evt_irq_pkg::*;
#(
  parameter int NUM_EXT      = 3,
  parameter int CLK_DIV      = 1000,
  parameter int TIMER_RELOAD = 4099
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] srcIn,
  input  logic               rdEn,
  output logic [NUM_EXT:0]   rdData,
  output logic               irq
);
  ctl_strobe_t      ctl;
  logic [NUM_EXT:0] pendingVec;
  logic [NUM_EXT:0] edgeVec;
  logic             tickSeen;

  evt_irq_ctrl #(
    .CLK_DIV     (CLK_DIV),
    .TIMER_RELOAD(TIMER_RELOAD)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .rdEn(rdEn),
    .ctl (ctl)
  );

  evt_irq_dpath #(
    .NUM_EXT(NUM_EXT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .ctl       (ctl),
    .pendingVec(pendingVec),
    .edgeVec   (edgeVec),
    .rdData    (rdData)
  );

  assign tickSeen = ctl.tick;
  assign irq      = |pendingVec;
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker #(
  parameter int NUM_EXT = 3,
  parameter int CLK_DIV = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdEn,
  input logic [NUM_EXT:0] rdData,
  input logic             irq,
  input logic [NUM_EXT:0] pendingVec,
  input logic [NUM_EXT:0] edgeVec,
  input logic             tickSeen
);
  AST_EDGE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeVec) |=> irq);  // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !rdEn) |=> irq);  // R2

  AST_READ_CLEARS_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> ((pendingVec & $past(rdData)) == ($past(edgeVec) & $past(rdData))));  // R5

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !(|edgeVec)) |=> !irq);  // R6

  generate
    if (CLK_DIV > 1) begin : g_tick
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
        tickSeen |=> !tickSeen);  // R7
    end
  endgenerate
endmodule

bind evt_irq_capture evt_irq_checker #(
  .NUM_EXT(NUM_EXT),
  .CLK_DIV(CLK_DIV)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .irq       (irq),
  .pendingVec(pendingVec),
  .edgeVec   (edgeVec),
  .tickSeen  (tickSeen)
);

// File: tb/tb_evt_irq_capture.sv
module tb_evt_irq_capture;
  localparam int NUM_EXT = 3;
  localparam int NS      = NUM_EXT + 1;
  localparam int CLK_DIV = 4;
  localparam int RELOAD  = 9;
  localparam int PERIOD  = (RELOAD + 1) * CLK_DIV;  // 40 cycles
  localparam int TBIT    = NUM_EXT;
  localparam logic [NS-1:0] EXT_MASK = {1'b0, {NUM_EXT{1'b1}}};

  // {pulse pattern, expected ext pending}
  localparam logic [5:0] VEC [6] = '{
    {3'b001, 3'b001}, {3'b010, 3'b010}, {3'b100, 3'b100},
    {3'b111, 3'b111}, {3'b101, 3'b101}, {3'b110, 3'b110}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_EXT-1:0] srcIn = '0;
  logic               rdEn = 1'b0;
  logic [NS-1:0]      rdData;
  logic               irq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  doneFlag = 0;

  always #2 clk = ~clk;

  evt_irq_capture #(
    .NUM_EXT(NUM_EXT), .CLK_DIV(CLK_DIV), .TIMER_RELOAD(RELOAD)
  ) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doRead(output logic [NS-1:0] v);
    @(negedge clk);
    rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  initial begin
    logic [NS-1:0] v;
    int hits, lastIdx, firstGapOk;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq after reset", irq, 0);
    rdEn = 1'b1;
    #1 chk(rdData == '0, "R9 pending after reset", rdData, 0);
    @(negedge clk);
    rdEn = 1'b0;

    // Vector table: single and coincident pulses (R1, R4)
    for (int k = 0; k < 6; k++) begin
      doRead(v);
      @(negedge clk);
      srcIn = VEC[k][5:3];
      repeat (3) @(negedge clk);
      srcIn = '0;
      repeat (3) @(negedge clk);
      doRead(v);
      chk((v & EXT_MASK) == NS'(VEC[k][2:0]), "R4 coincident capture",
          v & EXT_MASK, VEC[k][2:0]);
    end

    // R1: latency of exactly two edges after first sampling edge
    doRead(v);
    @(negedge clk);
    srcIn[0] = 1'b1;                 // sampled at E0
    @(posedge clk); @(posedge clk);  // E0, E1: edge visible after E1
    @(negedge clk);
    rdEn = 1'b1;
    #1 chk(rdData[0] == 1'b0, "R1 not yet pending after one edge", rdData[0], 0);
    // R5: edge coincides with this read, must survive
    @(negedge clk);
    rdEn = 1'b0;
    srcIn[0] = 1'b0;
    doRead(v);
    chk(v[0] == 1'b1, "R5 same-cycle edge kept", v[0], 1);
    doRead(v);
    chk(v[0] == 1'b0, "R5 cleared after read", v[0], 0);

    // R3: long pulse, read every cycle, count events
    hits = 0;
    @(negedge clk);
    rdEn = 1'b1;
    srcIn[1] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 20) srcIn[1] = 1'b0;
      #1 if (rdData[1]) hits++;
    end
    rdEn = 1'b0;
    chk(hits == 1, "R3 one event per long pulse", hits, 1);

    // R7: timer events with continuous reads
    hits = 0; lastIdx = -1; firstGapOk = 1;
    @(negedge clk);
    rdEn = 1'b1;
    for (int i = 0; i < 10 * PERIOD; i++) begin
      @(negedge clk);
      #1 if (rdData[TBIT]) begin
        if (lastIdx >= 0 && (i - lastIdx) != PERIOD) firstGapOk = 0;
        lastIdx = i;
        hits++;
      end
    end
    chk(hits == 10, "R7 timer event count", hits, 10);
    chk(firstGapOk == 1, "R7 timer period", firstGapOk, 1);

    // Align to just after a timer event for a quiet window
    v = '0;
    while (!v[TBIT]) begin
      @(negedge clk);
      #1 v = rdData;
    end
    @(negedge clk);
    rdEn = 1'b0;
    srcIn[2] = 1'b1;
    @(negedge clk);
    srcIn[2] = 1'b0;
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R2 sticky irq without read", irq, 1);
    #1 chk(rdData == '0, "R8 rdData zero without read", rdData, 0);
    @(negedge clk);
    rdEn = 1'b1;
    #1 chk(rdData == NS'(3'b100), "R2 sticky bit returned", rdData, 4);
    @(negedge clk);
    rdEn = 1'b0;
    chk(irq == 1'b0, "R6 irq low one cycle after read", irq, 0);

    // R9: reset clears a pending bit
    srcIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    srcIn[0] = 1'b0;
    chk(irq == 1'b1, "R1 pending before reset", irq, 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq cleared by reset", irq, 0);
    doRead(v);
    chk(v == '0, "R9 pending cleared by reset", v, 0);

    finishRun();
  end
endmodule